// File: doc/BRIEF.md
# Core-Affinity Request Dispatcher

The dispatcher takes remote-call requests that are ready to execute. Each request carries a function identifier, a handler address and the address of its unpacked argument storage. For every request it chooses one CPU core and pushes the request into that core's queue. The aim is to keep calls to the same function on the same core, so that core's caches and branch predictors stay warm. The choice also spreads calls to new functions evenly across the cores.

A small associative table holds one slot per core. Each slot records the function most recently sent to that core. An incoming identifier is compared against every slot in the same cycle. On a match, the request goes to the core that owns the matching slot. Otherwise, a rotating pointer names the core. In both cases the chosen core's slot takes the new identifier. The dispatcher checks the chosen core's full flag in the cycle it accepts a request. If that queue is full, the request waits at the input through a ready/valid handshake; it is never sent to another core. The accepted request appears on the push outputs one cycle after acceptance.

Top module: `affinity_dispatcher`

## Requirements
- R1: After reset every table slot is empty, the rotating pointer names core 0 and no push is asserted, so the first request after reset goes to core 0.
- R2: A request whose identifier equals the stored identifier of an occupied slot is sent to the core owning that slot.
- R3: A request that matches no occupied slot is sent to the core named by the rotating pointer.
- R4: The rotating pointer moves only when a non-matching request is accepted. It moves to the core after the one just chosen, and after core NUM_CORES-1 it wraps to core 0. A matching dispatch leaves it unchanged.
- R5: Every accepted request overwrites the chosen core's slot with its identifier and marks the slot occupied. The identifier that was there before no longer matches that core.
- R6: A request accepted at a clock edge raises exactly one bit of `q_push`, bit k for core k, during the following cycle. In that cycle `q_fptr`, `q_aptr` and `q_fid` carry that request's handler address, argument address and identifier. With no acceptance, `q_push` is all zeros.
- R7: `req_ready` is low exactly when the `q_full` bit of the core chosen for the present request is high. While it is low the request is held: nothing is pushed, the request is not sent to another core, and neither the table nor the pointer changes.
- R8: One request can be accepted on every clock cycle, with back-to-back requests producing pushes in consecutive cycles.
- R9: An empty slot never matches, whatever its stored identifier bits are. An identifier of 0 right after reset is therefore handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is accepted at this edge if valid |
| req_fid | input | FID_W | Function identifier |
| req_fptr | input | PTR_W | Handler address |
| req_aptr | input | PTR_W | Argument storage address |
| q_full | input | NUM_CORES | Per-core queue full flags, bit k for core k |
| q_push | output | NUM_CORES | One-hot queue push, registered |
| q_fptr | output | PTR_W | Handler address of the pushed request |
| q_aptr | output | PTR_W | Argument address of the pushed request |
| q_fid | output | FID_W | Identifier of the pushed request |

## Verification
The bench sends an identifier of 0 straight after reset. A design that ignored the occupied flags would treat it as a hit on core 0, would not move the pointer, and would send the next new function to core 0 a second time. It stalls both a miss and a hit on a full queue. A design that redirected the request, or that advanced the pointer or wrote the table during the stall, sends later requests to the wrong cores. Further cases cover pointer wrap from the last core to core 0, an evicted identifier that must then miss, and hits that must leave the pointer alone. A random phase with sparse full flags compares every cycle against a behavioural table model.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int DEF_CORES = 4;
  localparam int DEF_FID_W = 16;
  localparam int DEF_PTR_W = 32;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/affinity_cam.sv
module affinity_cam #(
  parameter int NUM_CORES = adp_pkg::DEF_CORES,
  parameter int FID_W     = adp_pkg::DEF_FID_W,
  parameter int IDX_W     = adp_pkg::idx_width(NUM_CORES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FID_W-1:0] lk_fid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [FID_W-1:0] wr_fid,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [FID_W-1:0]     slot_fid [NUM_CORES];
  logic [NUM_CORES-1:0] slot_vld;
  logic [NUM_CORES-1:0] match;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    assign match[g] = slot_vld[g] && (slot_fid[g] == lk_fid);

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[g] <= 1'b0;
        slot_fid[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_vld[g] <= 1'b1;
        slot_fid[g] <= wr_fid;
      end
    end
  end

  // lowest-numbered matching slot takes priority
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit = |match;

  AST_NO_HIT_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit); // R9

  AST_WRITE_RECALL: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> slot_vld[$past(wr_idx)] && (slot_fid[$past(wr_idx)] == $past(wr_fid))); // R5
endmodule

// File: rtl/rr_pointer.sv
module rr_pointer #(
  parameter int NUM_CORES = adp_pkg::DEF_CORES,
  parameter int IDX_W     = adp_pkg::idx_width(NUM_CORES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CORES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST); // R4

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr)); // R4
endmodule

// File: rtl/affinity_dispatcher.sv
module affinity_dispatcher #(
  parameter int NUM_CORES = adp_pkg::DEF_CORES,
  parameter int FID_W     = adp_pkg::DEF_FID_W,
  parameter int PTR_W     = adp_pkg::DEF_PTR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [FID_W-1:0]     req_fid,
  input  logic [PTR_W-1:0]     req_fptr,
  input  logic [PTR_W-1:0]     req_aptr,
  input  logic [NUM_CORES-1:0] q_full,
  output logic [NUM_CORES-1:0] q_push,
  output logic [PTR_W-1:0]     q_fptr,
  output logic [PTR_W-1:0]     q_aptr,
  output logic [FID_W-1:0]     q_fid
);
  localparam int IDX_W = adp_pkg::idx_width(NUM_CORES);

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] target;
  logic             accept;

  affinity_cam #(.NUM_CORES(NUM_CORES), .FID_W(FID_W), .IDX_W(IDX_W)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .lk_fid (req_fid),
    .wr_en  (accept),
    .wr_idx (target),
    .wr_fid (req_fid),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  rr_pointer #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_rr (
    .clk(clk),
    .rst(rst),
    .adv(accept && !hit),
    .ptr(rr_ptr)
  );

  assign target    = hit ? hit_idx : rr_ptr;
  assign req_ready = !q_full[target];
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_push <= '0;
      q_fptr <= '0;
      q_aptr <= '0;
      q_fid  <= '0;
    end else begin
      q_push <= accept ? (NUM_CORES'(1) << target) : '0;
      if (accept) begin
        q_fptr <= req_fptr;
        q_aptr <= req_aptr;
        q_fid  <= req_fid;
      end
    end
  end

  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_push)); // R6

  AST_ACCEPT_PUSHES: assert property (@(posedge clk) disable iff (rst)
    accept |=> ($countones(q_push) == 1)); // R6

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (q_push == '0)); // R7

  AST_STALL_PTR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(rr_ptr)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (q_push == '0)); // R1
endmodule

// File: tb/affinity_dispatcher_tb.sv
module affinity_dispatcher_tb;
  localparam int N  = 4;
  localparam int FW = 16;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [FW-1:0] req_fid = '0;
  logic [PW-1:0] req_fptr = '0;
  logic [PW-1:0] req_aptr = '0;
  logic [N-1:0]  q_full = '0;
  logic [N-1:0]  q_push;
  logic [PW-1:0] q_fptr;
  logic [PW-1:0] q_aptr;
  logic [FW-1:0] q_fid;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  affinity_dispatcher #(.NUM_CORES(N), .FID_W(FW), .PTR_W(PW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fid(req_fid), .req_fptr(req_fptr), .req_aptr(req_aptr),
    .q_full(q_full), .q_push(q_push), .q_fptr(q_fptr), .q_aptr(q_aptr), .q_fid(q_fid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: table, pointer, expected push
  bit            m_vld [N];
  logic [FW-1:0] m_fid [N];
  int            m_rr;
  logic [N-1:0]  e_push = '0;
  logic [PW-1:0] e_fptr, e_aptr;
  logic [FW-1:0] e_fid;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_fid[i] = '0; end
      m_rr   = 0;
      e_push = '0;
    end else if (!done) begin
      bit hit;
      int tgt;
      bit rdy;
      chk(q_push == e_push, "R6", "model push", q_push, e_push);
      if (e_push != '0) begin
        chk(q_fptr == e_fptr, "R6", "model fptr", q_fptr, e_fptr);
        chk(q_aptr == e_aptr, "R6", "model aptr", q_aptr, e_aptr);
        chk(q_fid == e_fid, "R6", "model fid", q_fid, e_fid);
      end
      hit = 1'b0;
      tgt = m_rr;
      for (int i = 0; i < N; i++) begin
        if (!hit && m_vld[i] && m_fid[i] == req_fid) begin hit = 1'b1; tgt = i; end
      end
      rdy = !q_full[tgt];
      chk(req_ready == rdy, "R7", "model ready", req_ready, rdy);
      if (req_valid && rdy) begin
        m_vld[tgt] = 1'b1;
        m_fid[tgt] = req_fid;
        if (!hit) m_rr = (tgt + 1) % N;
        e_push = '0;
        e_push[tgt] = 1'b1;
        e_fptr = req_fptr;
        e_aptr = req_aptr;
        e_fid  = req_fid;
      end else begin
        e_push = '0;
      end
    end
  end

  // one request, optionally stalled, then check its push
  task automatic send(input logic [FW-1:0] fid, input int exp_core, input string tag);
    logic [PW-1:0] fp, ap;
    logic [N-1:0]  want;
    fp = $urandom;
    ap = $urandom;
    @(posedge clk); #1;
    req_valid = 1'b1; req_fid = fid; req_fptr = fp; req_aptr = ap;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    want = '0;
    want[exp_core] = 1'b1;
    chk(q_push == want, tag, "push target", q_push, want);
    chk(q_fptr == fp && q_aptr == ap, tag, "pointers", q_fptr, fp);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000 && !done; wd++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(q_push == '0, "R1", "push after reset", q_push, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    send(16'd0,  0, "R1_R9");  // id 0 must miss: slot 0 invalid
    send(16'd10, 1, "R9");     // pointer advanced past core 0
    send(16'd11, 2, "R3");
    send(16'd12, 3, "R3");
    send(16'd10, 1, "R2");     // hit
    send(16'd13, 0, "R4");     // wrapped to 0, unchanged by hit
    send(16'd0,  1, "R5");     // id 0 evicted from core 0
    send(16'd10, 2, "R5");     // id 10 evicted from core 1
    // table: 0:13 1:0 2:10 3:11? no: core3 holds 12; pointer at 3

    // R7 miss stall on full core 3
    q_full = 4'b1000;
    @(posedge clk); #1;
    req_valid = 1'b1; req_fid = 16'd20; req_fptr = 32'hAAAA; req_aptr = 32'hBBBB;
    repeat (3) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7", "ready while full", req_ready, 0);
      chk(q_push == '0, "R7", "no push while full", q_push, 0);
    end
    @(posedge clk); #1 q_full = '0;
    @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(q_push == 4'b1000, "R7", "held request to same core", q_push, 4'b1000);
    send(16'd21, 0, "R7");     // pointer advanced once only

    // R7 hit stall on full core 2 (id 10)
    q_full = 4'b0100;
    @(posedge clk); #1;
    req_valid = 1'b1; req_fid = 16'd10;
    repeat (2) begin
      @(negedge clk);
      chk(q_push == '0, "R7", "hit stalled", q_push, 0);
    end
    @(posedge clk); #1 q_full = '0;
    @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(q_push == 4'b0100, "R7", "hit held to core 2", q_push, 4'b0100);
    send(16'd22, 1, "R4");     // hit left pointer at 1

    // R8 back-to-back hits: 0:21 1:22 2:10 3:20
    @(posedge clk); #1;
    req_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      req_fid = (k == 0) ? 16'd21 : (k == 1) ? 16'd22 : (k == 2) ? 16'd10 : 16'd20;
      @(negedge clk);
      if (k > 0) chk(q_push == (4'b1 << (k - 1)), "R8", "streamed push", q_push, 4'b1 << (k - 1));
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(q_push == 4'b1000, "R8", "last streamed push", q_push, 4'b1000);

    // random phase against the model
    for (int c = 0; c < 400; c++) begin
      @(posedge clk); #1;
      req_valid = ($urandom % 4) != 0;
      req_fid   = FW'($urandom % 7);
      req_fptr  = $urandom;
      req_aptr  = $urandom;
      q_full    = (($urandom % 3) == 0) ? N'($urandom) : '0;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; q_full = '0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule